// File: doc/BRIEF.md
# Receive Word FIFO Read Port

This block holds received 32-bit data words in a small FIFO and lets a processor read the oldest word through one data register on a simple request bus. A read may be 8, 16 or 32 bits wide; the byte enables pick the lanes. The write side is a plain push input with a full flag.

A mode register sets when the read pointer moves. In automatic mode, a data-register read consumes the head word. Bytes that were not read are dropped. A build-time parameter names one 16-bit half as the advancing half. A half-word read of the other half leaves the word in place, so a 16-bit host can read both halves. In manual mode, data reads never consume the word. Software moves to the next word by writing an advance bit to a command register with at least a 16-bit write. A read or an advance attempted while the FIFO is empty returns zero and sets a sticky underflow flag.

Top module: `rxword_read_port`

## Requirements
- R1: A data-register read returns each head-word byte whose byte enable is set, in its own lane (byte 0 on bits 7:0, byte 3 on bits 31:24). Lanes whose byte enable is clear read as zero. Valid enable patterns are 4'b1111, 4'b0011, 4'b1100 and one-hot.
- R2: Read data and `rd_valid` appear on the clock edge after the read request. `rd_valid` is low after a write request.
- R3: In automatic mode, a 32-bit or 8-bit data read of a non-empty FIFO consumes the head word, so the next read sees the following word.
- R4: In automatic mode with `ADV_HIGH_HALF`=0, a read with enables 4'b0011 consumes the word and a read with enables 4'b1100 does not. With `ADV_HIGH_HALF`=1 the two roles swap.
- R5: In manual mode, data reads of any width leave the word count and the head word unchanged.
- R6: Writing the command register (address 2) with bit 0 set and enables 0 and 1 both set consumes one word, in either mode. A command write that lacks either of those two enables has no effect.
- R7: A read of the command register returns zero.
- R8: A data read or a command advance while the FIFO is empty returns zero and leaves the count at zero. It also sets `underflow`. `underflow` stays set until a command write with bit 1 set and enables 0 and 1 set clears it. A new underflow in the same cycle wins over the clear.
- R9: `word_count` equals the number of stored words. `empty` is high exactly when the count is zero, and `full` is high exactly when the count equals `DEPTH`. A push while full is dropped. A push together with a pop leaves the count unchanged.
- R10: After reset the count is zero, `empty` is high, `underflow` is low and automatic mode is selected.
- R11: The mode register (address 1) bit 0 selects automatic mode (1) or manual mode (0). It is written when enable 0 is set and reads back on bit 0, with the other bits zero. Address 0 is the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push | input | 1 | Write one word into the FIFO |
| push_data | input | 32 | Word to store |
| full | output | 1 | FIFO holds DEPTH words |
| req | input | 1 | Bus request, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register select: 0 data, 1 mode, 2 command |
| be | input | 4 | Byte enables |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | rdata updated by last request |
| word_count | output | 5 | Stored words |
| empty | output | 1 | No word stored |
| underflow | output | 1 | Sticky empty-access flag |

## Verification
Directed sequences read a known word as one 32-bit access, as single bytes and as each half. This separates the advancing from the non-advancing widths and exposes lanes that are swapped or shifted. The same reads are repeated in manual mode to show that the word stays put. Command writes are sent with one byte enable and with two, to tell an ignored command from an acting one. The FIFO is drained to empty and filled past full to reach the underflow and drop boundaries. A seeded random mix of pushes, reads, mode changes and commands then runs against a queue model, which catches pointer and count slips that a short directed run would miss.

// File: rtl/rxp_pkg.sv
// Shared register addresses and constants for the receive word read port.
// Assumes a 32-bit data word split into four byte lanes.
package rxp_pkg;
    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_MODE = 2'd1,
        REG_CMD  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // command register bit positions
    localparam int CMD_ADV_BIT = 0;
    localparam int CMD_CLR_BIT = 1;
endpackage

// File: rtl/rxp_word_store.sv
// Circular word store with read and write pointers and an occupancy count.
// Assumes DEPTH is a power of two. Pushes while full are dropped; pops while
// empty are ignored (the controller is expected to gate them).
module rxp_word_store #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // storage write, no reset needed on the array
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // pointer and count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + PW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == $past(count)));
    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/rxp_lane_mux.sv
// Selects the byte lanes of the head word named by the byte enables.
// Lanes keep their position; disabled lanes read as zero.
module rxp_lane_mux #(
    parameter int LANES = 4,
    localparam int W    = LANES * 8
) (
    input  logic [W-1:0]     word,
    input  logic [LANES-1:0] be,
    output logic [W-1:0]     lanes
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // pass or blank one byte lane
        assign lanes[g*8 +: 8] = be[g] ? word[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/rxp_ctrl.sv
// Bus decode, mode register, advance policy and sticky underflow flag.
// Assumes one request per cycle. A half-word read on the non-advancing half
// keeps the word in automatic mode; every other data read consumes it.
module rxp_ctrl
    import rxp_pkg::*;
#(
    parameter bit ADV_HIGH_HALF = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [LANES-1:0] be,
    input  logic [WORD_W-1:0] wdata,
    input  logic             empty,
    output logic             pop,
    output logic             data_rd,
    output logic             auto_mode,
    output logic             underflow
);
    localparam logic [LANES-1:0] KEEP_BE = ADV_HIGH_HALF ? 4'b0011 : 4'b1100;

    logic cmd_ok, adv_cmd, clr_cmd, mode_wr, auto_pop, want_pop, uf_set;

    assign data_rd  = req && !wr && (addr == REG_DATA) && (be != '0);
    assign cmd_ok   = req && wr && (addr == REG_CMD) && be[0] && be[1];
    assign adv_cmd  = cmd_ok && wdata[CMD_ADV_BIT];
    assign clr_cmd  = cmd_ok && wdata[CMD_CLR_BIT];
    assign mode_wr  = req && wr && (addr == REG_MODE) && be[0];
    assign auto_pop = data_rd && auto_mode && (be != KEEP_BE);
    assign want_pop = auto_pop || adv_cmd;
    assign pop      = want_pop && !empty;
    assign uf_set   = (data_rd || adv_cmd) && empty;

    // mode register, automatic after reset
    always_ff @(posedge clk) begin
        if (!rst_n)       auto_mode <= 1'b1;
        else if (mode_wr) auto_mode <= wdata[0];
    end

    // sticky underflow: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)       underflow <= 1'b0;
        else if (uf_set)  underflow <= 1'b1;
        else if (clr_cmd) underflow <= 1'b0;
    end

    // R5
    manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !auto_mode && !(req && wr)) |-> !pop);
    // R8
    uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !(req && wr && addr == REG_CMD)) |=> underflow);
endmodule

// File: rtl/rxword_read_port.sv
// Top of the receive word read port: word store, lane mux, control and the
// registered read-data path. Assumes a single-cycle request bus with read
// data returned one clock after the request.
module rxword_read_port
    import rxp_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter bit ADV_HIGH_HALF = 1'b0,
    localparam int CW           = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    output logic              full,
    input  logic              req,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [LANES-1:0]  be,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rd_valid,
    output logic [CW-1:0]     word_count,
    output logic              empty,
    output logic              underflow
);
    logic [WORD_W-1:0] head, lane_word;
    logic              pop, data_rd, auto_mode;

    rxp_word_store #(.W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .head(head), .count(word_count), .empty(empty), .full(full)
    );

    rxp_lane_mux #(.LANES(LANES)) u_mux (
        .word(head), .be(be), .lanes(lane_word)
    );

    rxp_ctrl #(.ADV_HIGH_HALF(ADV_HIGH_HALF)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .be(be),
        .wdata(wdata), .empty(empty), .pop(pop), .data_rd(data_rd),
        .auto_mode(auto_mode), .underflow(underflow)
    );

    // registered read data and valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= req && !wr;
            if (req && !wr) begin
                case (reg_sel_e'(addr))
                    REG_DATA: rdata <= empty ? '0 : lane_word;
                    REG_MODE: rdata <= {{(WORD_W-1){1'b0}}, auto_mode};
                    default:  rdata <= '0;
                endcase
            end
        end
    end

    // R2
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr) |=> rd_valid);
    // R7
    cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && addr == REG_CMD) |=> (rdata == '0));
    // R8
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && empty && !push) |=> (rdata == '0 && word_count == '0 && underflow));
    // R3
    auto_word_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && auto_mode && be == 4'b1111 && !empty && !push)
            |=> (word_count == $past(word_count) - CW'(1)));
endmodule

// File: tb/test_rxword_read_port.sv
`timescale 1ns/1ps
module test_rxword_read_port;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push = 1'b0;
    logic [31:0]   push_data = '0;
    logic          full;
    logic          req = 1'b0, wr = 1'b0;
    logic [1:0]    addr = '0;
    logic [3:0]    be = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          rd_valid;
    logic [CW-1:0] word_count;
    logic          empty, underflow;

    int total = 0, bad = 0;
    bit done = 1'b0;

    logic [31:0] q[$];
    bit m_auto = 1'b1;
    bit m_uf   = 1'b0;

    always #4 clk = ~clk;

    rxword_read_port #(.DEPTH(DEPTH), .ADV_HIGH_HALF(1'b0)) i_rxword_read_port (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .full(full),
        .req(req), .wr(wr), .addr(addr), .be(be), .wdata(wdata), .rdata(rdata),
        .rd_valid(rd_valid), .word_count(word_count), .empty(empty),
        .underflow(underflow)
    );

    function automatic logic [31:0] lane_exp(input logic [31:0] w, input logic [3:0] b);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) if (b[i]) r[i*8 +: 8] = w[i*8 +: 8];
        return r;
    endfunction

    // R4: low half advances, high half keeps (ADV_HIGH_HALF=0)
    function automatic bit adv_exp(input logic [3:0] b);
        return b != 4'b1100;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus access with optional push; model updated and outputs checked
    task automatic op(input bit w, input logic [1:0] a, input logic [3:0] b,
                      input logic [31:0] d, input bit p, input logic [31:0] pd,
                      input string tag);
        logic [31:0] exp_rd = '0;
        bit pre_empty = (q.size() == 0);
        bit pre_full  = (q.size() == DEPTH);
        bit do_pop = 1'b0, set_uf = 1'b0, clr = 1'b0;
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; be = b; wdata = d; push = p; push_data = pd;
        if (!w) begin
            if (a == 2'd0 && b != 0) begin
                exp_rd = pre_empty ? 32'h0 : lane_exp(q[0], b);
                if (pre_empty) set_uf = 1'b1;
                else if (m_auto && adv_exp(b)) do_pop = 1'b1;
            end else if (a == 2'd1) exp_rd = {31'b0, m_auto};
        end else begin
            if (a == 2'd1 && b[0]) m_auto = d[0];
            if (a == 2'd2 && b[0] && b[1]) begin
                if (d[0]) begin
                    if (pre_empty) set_uf = 1'b1; else do_pop = 1'b1;
                end
                clr = d[1];
            end
        end
        if (do_pop) void'(q.pop_front());
        if (p && !pre_full) q.push_back(pd);
        m_uf = set_uf ? 1'b1 : (clr ? 1'b0 : m_uf);
        @(negedge clk);
        req = 1'b0; push = 1'b0; wr = 1'b0; be = '0;
        if (!w) chk(rdata == exp_rd, {tag, " rdata"}, rdata, exp_rd);
        chk(rd_valid == !w, "R2 rd_valid", 32'(rd_valid), 32'(!w));
        chk(word_count == CW'(q.size()), {tag, " count R9"}, 32'(word_count), q.size());
        chk(empty == (q.size() == 0), "R9 empty", 32'(empty), 32'(q.size() == 0));
        chk(full == (q.size() == DEPTH), "R9 full", 32'(full), 32'(q.size() == DEPTH));
        chk(underflow == m_uf, "R8 underflow", 32'(underflow), 32'(m_uf));
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) op(1'b0, 2'd3, 4'h0, 0, 1'b1, 32'hA0B1C2D3 + 32'(i * 32'h01010101), "R9 push");
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(word_count == 0, "R10 count", 32'(word_count), 0);
        chk(empty == 1'b1, "R10 empty", 32'(empty), 1);
        chk(underflow == 1'b0, "R10 underflow", 32'(underflow), 0);
        op(1'b0, 2'd1, 4'hF, 0, 1'b0, 0, "R10 R11 mode auto");

        fill(6);
        op(1'b0, 2'd0, 4'hF, 0, 1'b0, 0, "R1 R3 word read");
        op(1'b0, 2'd0, 4'h4, 0, 1'b0, 0, "R1 R3 byte read");
        op(1'b0, 2'd0, 4'hC, 0, 1'b0, 0, "R4 high half keep");
        op(1'b0, 2'd0, 4'h3, 0, 1'b0, 0, "R4 low half advance");
        op(1'b1, 2'd1, 4'h1, 32'h0, 1'b0, 0, "R11 mode write");
        op(1'b0, 2'd1, 4'hF, 0, 1'b0, 0, "R11 mode readback");
        for (int i = 0; i < 4; i++) op(1'b0, 2'd0, 4'(1 << i), 0, 1'b0, 0, "R5 R1 manual byte");
        op(1'b0, 2'd0, 4'hF, 0, 1'b0, 0, "R5 manual word");
        op(1'b1, 2'd2, 4'h1, 32'h1, 1'b0, 0, "R6 narrow cmd ignored");
        op(1'b1, 2'd2, 4'h3, 32'h1, 1'b0, 0, "R6 cmd advance");
        op(1'b0, 2'd2, 4'hF, 0, 1'b0, 0, "R7 cmd read");
        while (q.size() > 0) op(1'b1, 2'd2, 4'hF, 32'h1, 1'b0, 0, "R6 drain");
        op(1'b0, 2'd0, 4'hF, 0, 1'b0, 0, "R8 empty read");
        op(1'b1, 2'd2, 4'h3, 32'h2, 1'b0, 0, "R8 clear");
        op(1'b1, 2'd2, 4'h3, 32'h1, 1'b0, 0, "R8 empty advance");
        op(1'b1, 2'd2, 4'h3, 32'h3, 1'b0, 0, "R8 set beats clear");
        op(1'b1, 2'd1, 4'h1, 32'h1, 1'b0, 0, "R11 back to auto");
        fill(DEPTH + 2);
        op(1'b0, 2'd0, 4'hF, 0, 1'b1, 32'h5555AAAA, "R9 pop with push");

        for (int n = 0; n < 4000; n++) begin
            logic [3:0] bes[7] = '{4'hF, 4'h3, 4'hC, 4'h1, 4'h2, 4'h4, 4'h8};
            int k = $urandom % 10;
            bit w = (k >= 7);
            logic [1:0] a = (k < 6) ? 2'd0 : (k == 6) ? 2'd1 : ((k == 9) ? 2'd1 : 2'd2);
            op(w, a, bes[$urandom % 7], $urandom, ($urandom % 2) == 0, $urandom, "R1 R3 R4 R5 R6 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule